// File: doc/BRIEF.md
# Crystal Load Compensation Update Sequencer

This block paces the temperature-compensation updates of a crystal load-capacitance array. While idle it counts a fixed interval of clock ticks. When the interval runs out, or when the host asks for a manual conversion, it launches a conversion: it pulses a launch strobe for one cycle and raises busy. It then waits for an external result-valid input. On that cycle it takes a temperature sample and a computed capacitance code from its inputs.

At the end of a conversion the block may load a new array code. The new code is the computed code plus a signed user offset, held in a local register. Each offset step is one unit capacitor. The sum is clamped to the range of the unsigned array code. An automatic conversion loads a new code only when the temperature differs from the previous sample. A manual conversion always loads a new code, so a changed offset can be applied at once. A manual request that arrives during a conversion is kept and runs as soon as that conversion finishes.

Top module: `capcomp_sequencer`

## Requirements
- R1: After reset, array_code is 0, busy and conv_start are 0, and the offset register is 0, so the first conversion loads the unchanged computed code.
- R2: conv_start is high for exactly one cycle. busy rises on the same edge and stays high while result_valid is low. busy falls on the edge that samples result_valid high while busy.
- R3: With no manual request, a conversion is launched after exactly IDLE_TICKS consecutive idle cycles. The count starts on leaving reset or on the edge that ends a conversion.
- R4: When a conversion loads the array, array_code becomes code_in plus the offset. The offset is read as 8-bit two's complement with bit 7 as the sign, and one offset step is one code step. The value is taken on the edge that ends the conversion.
- R5: The sum is clamped. It never goes below 0 and never above 2^CODE_W-1, and it does not wrap.
- R6: An automatic conversion whose temperature equals the previous conversion's temperature leaves array_code unchanged. The first conversion after reset always loads.
- R7: A manual conversion always loads array_code with the offset that is current at its end, even if the temperature is unchanged.
- R8: A manual request made while busy is held. Its conversion launches one cycle after busy falls, and it yields exactly one extra conversion.
- R9: result_valid while idle is ignored, and array_code does not change while idle.
- R10: Writing the offset does not change array_code by itself. The new value is used only by the next conversion that loads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ofs_wr_en | input | 1 | Write strobe for the offset register |
| ofs_wr_data | input | OFS_W (8) | Signed offset value to store |
| manual_req | input | 1 | One-cycle request for a manual conversion |
| temp_in | input | TEMP_W (10) | Temperature sample, taken with result_valid |
| code_in | input | CODE_W (8) | Computed capacitance code, taken with result_valid |
| result_valid | input | 1 | Marks the cycle in which temp_in and code_in are valid |
| array_code | output | CODE_W (8) | Code applied to the capacitance array |
| busy | output | 1 | High from launch until the return to idle |
| conv_start | output | 1 | One-cycle strobe when a conversion is launched |

## Verification
The assertions assume that temp_in and code_in are valid in the cycle in which result_valid is high while busy. They also assume that manual_req and ofs_wr_en are single-cycle strobes. The bench drives every input on the falling clock edge and raises result_valid for one cycle only. It changes the offset only between conversions, and it fits each manual scenario inside one idle interval so that no automatic launch interferes. The one deliberate exception is a result_valid pulse while idle, which exercises the ignore rule.

// File: rtl/capcomp_pkg.sv
`timescale 1ns/1ps
// Shared types for the compensation update sequencer.
package capcomp_pkg;
    // Sequencer states: waiting out the idle interval, or waiting for a result.
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } seq_state_e;
endpackage

// File: rtl/capcomp_idle_timer.sv
`timescale 1ns/1ps
// Idle interval timer.
// Counts clock ticks while run is high. Raises expire in the last tick of the
// interval. Assumes run drops when expire is acted on, so the count restarts
// from zero on the next idle entry. IDLE_TICKS must be at least 1.
module capcomp_idle_timer #(
    parameter int IDLE_TICKS = 60_000_000,
    localparam int CNT_W = $clog2(IDLE_TICKS + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expire
);
    logic [CNT_W-1:0] cnt;

    // Last tick of the interval while running.
    assign expire = run && (cnt == CNT_W'(IDLE_TICKS - 1));

    // Tick counter: cleared when not running or at expiry, else incremented.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || expire) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/capcomp_offset_reg.sv
`timescale 1ns/1ps
// User aging offset register.
// Holds a signed offset in two's complement. Resets to zero. Any write
// replaces the whole value.
module capcomp_offset_reg #(
    parameter int OFS_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [OFS_W-1:0] wr_data,
    output logic [OFS_W-1:0] ofs
);
    // Offset storage with synchronous clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ofs <= '0;
        end else if (wr_en) begin
            ofs <= wr_data;
        end
    end
endmodule

// File: rtl/capcomp_offset_sat.sv
`timescale 1ns/1ps
// Saturating signed-offset adder.
// Adds a two's-complement offset to an unsigned code. Clamps the result to
// the range [0, 2^CODE_W-1]. Purely combinational.
module capcomp_offset_sat #(
    parameter int CODE_W = 8,
    parameter int OFS_W  = 8,
    localparam int SUM_W = ((CODE_W > OFS_W) ? CODE_W : OFS_W) + 2
) (
    input  logic [CODE_W-1:0] code_in,
    input  logic [OFS_W-1:0]  ofs,
    output logic [CODE_W-1:0] code_out
);
    logic [SUM_W-1:0] code_x;
    logic [SUM_W-1:0] ofs_x;
    logic [SUM_W-1:0] sum;

    // Widen both operands; the offset is sign-extended.
    assign code_x = SUM_W'(code_in);
    assign ofs_x  = {{(SUM_W - OFS_W){ofs[OFS_W-1]}}, ofs};
    assign sum    = code_x + ofs_x;

    // Clamp: a negative sum goes to zero, an oversized sum goes to all ones.
    always_comb begin
        if (sum[SUM_W-1]) begin
            code_out = '0;
        end else if (|sum[SUM_W-2:CODE_W]) begin
            code_out = {CODE_W{1'b1}};
        end else begin
            code_out = sum[CODE_W-1:0];
        end
    end
endmodule

// File: rtl/capcomp_sequencer.sv
`timescale 1ns/1ps
// Compensation update sequencer (top).
// Launches a conversion after each idle interval, or on a manual request.
// Waits for result_valid, then loads array_code with the saturated sum of
// code_in and the user offset. An automatic conversion loads only if the
// temperature changed. A manual conversion always loads. Assumes temp_in and
// code_in are valid in the cycle result_valid is high while busy.
module capcomp_sequencer
    import capcomp_pkg::*;
#(
    parameter int CODE_W     = 8,
    parameter int OFS_W      = 8,
    parameter int TEMP_W     = 10,
    parameter int IDLE_TICKS = 60_000_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ofs_wr_en,
    input  logic [OFS_W-1:0]  ofs_wr_data,
    input  logic              manual_req,
    input  logic [TEMP_W-1:0] temp_in,
    input  logic [CODE_W-1:0] code_in,
    input  logic              result_valid,
    output logic [CODE_W-1:0] array_code,
    output logic              busy,
    output logic              conv_start
);
    seq_state_e        state;
    logic              pend;
    logic              man_run;
    logic              have_prev;
    logic [TEMP_W-1:0] prev_temp;
    logic [OFS_W-1:0]  ofs;
    logic [CODE_W-1:0] sat_code;
    logic              expire;
    logic              launch;
    logic              done;
    logic              upd;

    capcomp_idle_timer #(.IDLE_TICKS(IDLE_TICKS)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (state == ST_IDLE),
        .expire (expire)
    );

    capcomp_offset_reg #(.OFS_W(OFS_W)) u_ofs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (ofs_wr_en),
        .wr_data (ofs_wr_data),
        .ofs     (ofs)
    );

    capcomp_offset_sat #(.CODE_W(CODE_W), .OFS_W(OFS_W)) u_sat (
        .code_in  (code_in),
        .ofs      (ofs),
        .code_out (sat_code)
    );

    // Launch, completion and load-gating decisions.
    assign launch = (state == ST_IDLE) && (pend || expire);
    assign done   = (state == ST_WAIT) && result_valid;
    assign upd    = man_run || !have_prev || (temp_in != prev_temp);
    assign busy   = (state == ST_WAIT);

    // State register: idle to wait on launch, wait to idle on result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else if (launch) begin
            state <= ST_WAIT;
        end else if (done) begin
            state <= ST_IDLE;
        end
    end

    // Pending manual request; one taken at launch, a same-cycle new one kept.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= 1'b0;
        end else if (launch) begin
            pend <= manual_req;
        end else begin
            pend <= pend | manual_req;
        end
    end

    // Launch strobe and kind of the running conversion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            conv_start <= 1'b0;
            man_run    <= 1'b0;
        end else begin
            conv_start <= launch;
            if (launch) begin
                man_run <= pend;
            end
        end
    end

    // Result capture: remember temperature, load array code when allowed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_temp  <= '0;
            have_prev  <= 1'b0;
            array_code <= '0;
        end else if (done) begin
            prev_temp <= temp_in;
            have_prev <= 1'b1;
            if (upd) begin
                array_code <= sat_code;
            end
        end
    end

    AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start); // R2
    AST_START_WITH_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> busy); // R2
    AST_CODE_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(busy) |-> $stable(array_code)); // R9
    AST_SAME_TEMP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !man_run && have_prev && temp_in == prev_temp) |=> $stable(array_code)); // R6
    AST_NO_WRAP_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (done && upd && !ofs[OFS_W-1]) |=> (array_code >= $past(code_in))); // R5
    AST_NO_WRAP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (done && upd && ofs[OFS_W-1]) |=> (array_code <= $past(code_in))); // R5
    AST_PEND_RELAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
        (done && pend) |=> ##1 conv_start); // R8
endmodule

// File: tb/capcomp_sequencer_tb.sv
`timescale 1ns/1ps
// Directed bench for the compensation update sequencer.
module capcomp_sequencer_tb;
    localparam int CODE_W = 8;
    localparam int OFS_W  = 8;
    localparam int TEMP_W = 10;
    localparam int NTICK  = 40;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ofs_wr_en = 1'b0;
    logic [OFS_W-1:0]  ofs_wr_data = '0;
    logic              manual_req = 1'b0;
    logic [TEMP_W-1:0] temp_in = '0;
    logic [CODE_W-1:0] code_in = '0;
    logic              result_valid = 1'b0;
    logic [CODE_W-1:0] array_code;
    logic              busy;
    logic              conv_start;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    capcomp_sequencer #(
        .CODE_W(CODE_W), .OFS_W(OFS_W), .TEMP_W(TEMP_W), .IDLE_TICKS(NTICK)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .ofs_wr_en(ofs_wr_en), .ofs_wr_data(ofs_wr_data),
        .manual_req(manual_req), .temp_in(temp_in), .code_in(code_in),
        .result_valid(result_valid), .array_code(array_code), .busy(busy),
        .conv_start(conv_start)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic write_ofs(input logic [OFS_W-1:0] v);
        @(negedge clk);
        ofs_wr_en = 1'b1;
        ofs_wr_data = v;
        @(negedge clk);
        ofs_wr_en = 1'b0;
    endtask

    task automatic pulse_manual();
        @(negedge clk);
        manual_req = 1'b1;
        @(negedge clk);
        manual_req = 1'b0;
    endtask

    // Count falling edges until conv_start is seen, then check the strobe shape.
    task automatic wait_launch(output int n);
        n = 0;
        while (!conv_start && n < 1000) begin
            @(negedge clk);
            n++;
        end
        chk(busy == 1'b1, "R2", "busy with conv_start", int'(busy), 1);
        @(negedge clk);
        chk(conv_start == 1'b0, "R2", "conv_start one cycle", int'(conv_start), 0);
    endtask

    // Present a result for one cycle and check the loaded code.
    task automatic finish_conv(input int t, input int c, input int exp, input string req);
        @(negedge clk);
        temp_in = TEMP_W'(t);
        code_in = CODE_W'(c);
        result_valid = 1'b1;
        @(negedge clk);
        result_valid = 1'b0;
        chk(busy == 1'b0, "R2", "busy falls after result", int'(busy), 0);
        chk(array_code == CODE_W'(exp), req, "array_code", int'(array_code), exp);
    endtask

    task automatic manual_conv(input logic [OFS_W-1:0] o, input int t, input int c,
                               input int exp, input string req);
        int n;
        write_ofs(o);
        pulse_manual();
        wait_launch(n);
        finish_conv(t, c, exp, req);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk(array_code == 0, "R1", "reset array_code", int'(array_code), 0);
        chk(busy == 1'b0, "R1", "reset busy", int'(busy), 0);
        chk(conv_start == 1'b0, "R1", "reset conv_start", int'(conv_start), 0);
    endtask

    task automatic t_first_auto();
        int n;
        rst_n = 1'b1;
        wait_launch(n);
        chk(n == NTICK, "R3", "idle cycles after reset", n, NTICK);
        finish_conv(100, 50, 50, "R1");   // zero offset, first conversion loads (R6)
    endtask

    task automatic t_same_temp_auto();
        int n;
        write_ofs(8'd5);
        chk(array_code == 50, "R10", "offset write alone", int'(array_code), 50);
        wait_launch(n);
        finish_conv(100, 70, 50, "R6");
    endtask

    task automatic t_changed_temp_auto();
        int n;
        wait_launch(n);
        chk(n == NTICK, "R3", "idle cycles after conversion", n, NTICK);
        finish_conv(101, 70, 75, "R4");
    endtask

    task automatic t_manual_and_sat();
        manual_conv(8'hFD, 101, 70, 67, "R7");   // -3, same temperature
        manual_conv(8'd20, 101, 250, 255, "R5");
        manual_conv(8'hEC, 101, 10, 0, "R5");    // -20
        manual_conv(8'h80, 101, 200, 72, "R4");  // -128
        manual_conv(8'h7F, 101, 0, 127, "R4");   // +127
    endtask

    task automatic t_idle_result_ignored();
        @(negedge clk);
        temp_in = 10'd300;
        code_in = 8'd9;
        result_valid = 1'b1;
        @(negedge clk);
        result_valid = 1'b0;
        chk(array_code == 127, "R9", "idle result_valid", int'(array_code), 127);
        chk(busy == 1'b0, "R9", "idle busy", int'(busy), 0);
    endtask

    task automatic t_pending_manual();
        int n;
        int seen;
        pulse_manual();
        wait_launch(n);
        pulse_manual();                       // arrives while busy
        repeat (8) @(negedge clk);
        chk(busy == 1'b1, "R2", "busy held without result", int'(busy), 1);
        finish_conv(101, 1, 128, "R7");
        chk(conv_start == 1'b0, "R8", "no strobe at busy fall", int'(conv_start), 0);
        @(negedge clk);
        chk(conv_start == 1'b1, "R8", "pending launch next cycle", int'(conv_start), 1);
        @(negedge clk);
        finish_conv(101, 2, 129, "R8");
        seen = 0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (conv_start || busy) seen++;
        end
        chk(seen == 0, "R8", "single pending conversion", seen, 0);
    endtask

    initial begin
        t_reset();
        t_first_auto();
        t_same_temp_auto();
        t_changed_temp_auto();
        t_manual_and_sat();
        t_idle_result_ignored();
        t_pending_manual();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(8 * 150000);
        failures++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule